// File: doc/BRIEF.md
# Branch Target Buffer with Two-Bit Direction Counters

This block sits beside the instruction fetch stage and guesses where fetch should go next. It keeps a small direct-mapped table. Each row records a branch's address as a tag, the address that branch last jumped to, and a two-bit saturating counter that tracks how the branch has tended to go. For each fetch address presented, the block answers one cycle later with a predicted next PC. That answer is the stored target when the row matches and its counter leans taken. In every other case it is the sequential address, PC plus four.

When a branch resolves further down the pipeline, the update port receives the branch address, the real target, the real direction, and the next PC that fetch used for it. The block then creates or refreshes the row and moves the counter. One cycle later it raises a mispredict flag together with the correct next PC, so the surrounding pipeline can discard the wrong-path instructions and restart fetch. Because the counter has hysteresis, a branch that closes a loop costs one wrong guess per loop run, and that guess falls on the exit.

Top module: `btb_predictor`

## Requirements
- R1: After synchronous reset every row is empty, and pred_valid and mispredict are low. A lookup issued right after reset returns fetch PC plus four with pred_taken low.
- R2: pred_valid is high in exactly the cycle that follows a cycle with fetch_valid high. A lookup that misses returns fetch PC plus four with pred_taken low.
- R3: On a tag match, the upper bit of the row's counter selects the answer. When it is 1, pred_taken is 1 and pred_npc is the stored target. When it is 0, pred_taken is 0 and pred_npc is PC plus four.
- R4: The row is chosen by PC bits [5:2], and PC bits [31:6] form the tag. A different PC that maps to the same row does not hit. Allocating a row for it evicts the earlier branch.
- R5: A taken update that misses fills the row with valid set, the tag, the target and counter 2'b10 (weakly taken). A not-taken update that misses leaves the table unchanged.
- R6: The counter uses 00 strongly not taken, 01 weakly not taken, 10 weakly taken and 11 strongly taken. Each update that hits adds one for taken and subtracts one for not taken, and the counter saturates at 11 and at 00.
- R7: A row at strongly taken that sees one not-taken outcome still predicts taken. A loop branch is therefore mispredicted only on its exit.
- R8: A taken update that hits replaces the stored target with the new target.
- R9: One cycle after upd_valid, mispredict is high exactly when the resolved next PC differs from upd_pred_npc. The resolved next PC is upd_target if taken and upd_pc plus four otherwise. redirect_pc carries the resolved next PC.
- R10: When a lookup and an update reach the same row in the same cycle, the lookup returns the contents from before the update. The update is visible to the next lookup.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Lookup request this cycle |
| fetch_pc | input | 32 | Fetch address to look up |
| pred_valid | output | 1 | Prediction for last cycle's lookup is present |
| pred_taken | output | 1 | Prediction says taken |
| pred_npc | output | 32 | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is reported |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_target | input | 32 | Actual target of the resolved branch |
| upd_taken | input | 1 | Actual direction of the resolved branch |
| upd_pred_npc | input | 32 | Next PC that fetch used after the branch |
| mispredict | output | 1 | Fetch followed the wrong path; flush |
| redirect_pc | output | 32 | Correct next PC to refetch from |

## Verification
A row that holds the wrong tag, target, valid bit or counter shows up on pred_npc at the first lookup of that row. That lookup answers one cycle after it is issued. The bench therefore follows every update with a lookup of the same address and compares the answer with the target or the sequential address. Counter faults such as wrap-around or missing hysteresis only appear after a run of outcomes in one direction. For that reason the counter is pushed against both limits and then reversed, so the first lookup after the reversal gives the wrong direction if the counter is faulty. An error in the mispredict compare reaches mispredict and redirect_pc one cycle after the update.

// File: rtl/btb_pkg.sv
package btb_pkg;

  typedef logic [1:0] dir_ctr_t;

  localparam dir_ctr_t DIR_STRONG_NT = 2'b00;
  localparam dir_ctr_t DIR_WEAK_NT   = 2'b01;
  localparam dir_ctr_t DIR_WEAK_T    = 2'b10;
  localparam dir_ctr_t DIR_STRONG_T  = 2'b11;

  // Saturating step of the direction counter.
  function automatic dir_ctr_t dir_step(input dir_ctr_t cur, input logic went_taken);
    dir_ctr_t nxt;
    nxt = cur;
    if (went_taken) begin
      if (cur != DIR_STRONG_T) nxt = cur + 2'd1;
    end else begin
      if (cur != DIR_STRONG_NT) nxt = cur - 2'd1;
    end
    return nxt;
  endfunction

  function automatic logic dir_says_taken(input dir_ctr_t cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/btb_meta_bank.sv
// Valid bits, tags and direction counters. Lookup side reads synchronously
// (read-before-write at the edge); the update side reads asynchronously for
// its read-modify-write.
module btb_meta_bank
  import btb_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int TAG_W = 26
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_en,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             lk_valid_q,
  output logic [TAG_W-1:0] lk_tag_q,
  output dir_ctr_t         lk_ctr_q,
  input  logic [IDX_W-1:0] up_idx,
  output logic             up_valid,
  output logic [TAG_W-1:0] up_tag,
  output dir_ctr_t         up_ctr,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  dir_ctr_t         wr_ctr
);
  localparam int ROWS = 1 << IDX_W;

  logic             row_valid [ROWS];
  logic [TAG_W-1:0] row_tag   [ROWS];
  dir_ctr_t         row_ctr   [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic hit_wr;
    assign hit_wr = wr_en && (up_idx == IDX_W'(r));
    always_ff @(posedge clk) begin
      if (rst) begin
        row_valid[r] <= 1'b0;
        row_tag[r]   <= '0;
        row_ctr[r]   <= DIR_STRONG_NT;
      end else if (hit_wr) begin
        row_valid[r] <= 1'b1;
        row_tag[r]   <= wr_tag;
        row_ctr[r]   <= wr_ctr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_valid_q <= 1'b0;
      lk_tag_q   <= '0;
      lk_ctr_q   <= DIR_STRONG_NT;
    end else if (lk_en) begin
      lk_valid_q <= row_valid[lk_idx];
      lk_tag_q   <= row_tag[lk_idx];
      lk_ctr_q   <= row_ctr[lk_idx];
    end
  end

  assign up_valid = row_valid[up_idx];
  assign up_tag   = row_tag[up_idx];
  assign up_ctr   = row_ctr[up_idx];

endmodule

// File: rtl/btb_target_ram.sv
// Simple dual-port target store: one write port, one registered read port.
module btb_target_ram #(
  parameter int IDX_W = 4,
  parameter int PC_W  = 32
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [PC_W-1:0]  wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] raddr,
  output logic [PC_W-1:0]  rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [PC_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/btb_update_ctl.sv
// Decides what an incoming resolved branch writes and whether fetch erred.
module btb_update_ctl
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int TAG_W = 26
) (
  input  logic             upd_valid,
  input  logic [PC_W-1:0]  upd_pc,
  input  logic [PC_W-1:0]  upd_target,
  input  logic             upd_taken,
  input  logic [PC_W-1:0]  upd_pred_npc,
  input  logic [TAG_W-1:0] upd_tag,
  input  logic             ent_valid,
  input  logic [TAG_W-1:0] ent_tag,
  input  dir_ctr_t         ent_ctr,
  output logic             meta_we,
  output dir_ctr_t         meta_ctr,
  output logic             tgt_we,
  output logic             wrong_path,
  output logic [PC_W-1:0]  resolved_npc
);
  logic ent_hit;

  assign ent_hit = ent_valid && (ent_tag == upd_tag);

  always_comb begin
    meta_we  = 1'b0;
    meta_ctr = DIR_WEAK_T;
    tgt_we   = 1'b0;
    if (upd_valid) begin
      if (ent_hit) begin
        meta_we  = 1'b1;
        meta_ctr = dir_step(ent_ctr, upd_taken);
        tgt_we   = upd_taken;
      end else if (upd_taken) begin
        meta_we  = 1'b1;
        meta_ctr = DIR_WEAK_T;
        tgt_we   = 1'b1;
      end
    end
  end

  assign resolved_npc = upd_taken ? upd_target : (upd_pc + PC_W'(4));
  assign wrong_path   = upd_valid && (resolved_npc != upd_pred_npc);

endmodule

// File: rtl/btb_lookup_sel.sv
// Turns the registered row read into the predicted next PC.
module btb_lookup_sel
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int TAG_W = 26
) (
  input  logic [PC_W-1:0]  pc_q,
  input  logic [TAG_W-1:0] pc_tag_q,
  input  logic             row_valid,
  input  logic [TAG_W-1:0] row_tag,
  input  dir_ctr_t         row_ctr,
  input  logic [PC_W-1:0]  row_target,
  output logic             taken,
  output logic [PC_W-1:0]  npc
);
  logic row_hit;

  assign row_hit = row_valid && (row_tag == pc_tag_q);
  assign taken   = row_hit && dir_says_taken(row_ctr);
  assign npc     = taken ? row_target : (pc_q + PC_W'(4));

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  parameter int OFS_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fetch_valid,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_valid,
  output logic            pred_taken,
  output logic [PC_W-1:0] pred_npc,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic [PC_W-1:0] upd_target,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_pred_npc,
  output logic            mispredict,
  output logic [PC_W-1:0] redirect_pc
);
  localparam int TAG_W = PC_W - IDX_W - OFS_W;

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] up_tag;
  logic [PC_W-1:0]  pc_q;
  logic             lk_vq;

  logic             rd_valid;
  logic [TAG_W-1:0] rd_tag;
  dir_ctr_t         rd_ctr;
  logic [PC_W-1:0]  rd_target;

  logic             ent_valid;
  logic [TAG_W-1:0] ent_tag;
  dir_ctr_t         ent_ctr;

  logic             meta_we, tgt_we, wrong_path;
  dir_ctr_t         meta_ctr;
  logic [PC_W-1:0]  resolved_npc;

  assign lk_idx = fetch_pc[OFS_W +: IDX_W];
  assign up_idx = upd_pc[OFS_W +: IDX_W];
  assign up_tag = upd_pc[PC_W-1 -: TAG_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_vq <= 1'b0;
      pc_q  <= '0;
    end else begin
      lk_vq <= fetch_valid;
      if (fetch_valid) pc_q <= fetch_pc;
    end
  end

  btb_meta_bank #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_meta (
    .clk        (clk),
    .rst        (rst),
    .lk_en      (fetch_valid),
    .lk_idx     (lk_idx),
    .lk_valid_q (rd_valid),
    .lk_tag_q   (rd_tag),
    .lk_ctr_q   (rd_ctr),
    .up_idx     (up_idx),
    .up_valid   (ent_valid),
    .up_tag     (ent_tag),
    .up_ctr     (ent_ctr),
    .wr_en      (meta_we),
    .wr_tag     (up_tag),
    .wr_ctr     (meta_ctr)
  );

  btb_target_ram #(.IDX_W(IDX_W), .PC_W(PC_W)) u_tgt (
    .clk   (clk),
    .we    (tgt_we),
    .waddr (up_idx),
    .wdata (upd_target),
    .re    (fetch_valid),
    .raddr (lk_idx),
    .rdata (rd_target)
  );

  btb_update_ctl #(.PC_W(PC_W), .TAG_W(TAG_W)) u_upd (
    .upd_valid    (upd_valid),
    .upd_pc       (upd_pc),
    .upd_target   (upd_target),
    .upd_taken    (upd_taken),
    .upd_pred_npc (upd_pred_npc),
    .upd_tag      (up_tag),
    .ent_valid    (ent_valid),
    .ent_tag      (ent_tag),
    .ent_ctr      (ent_ctr),
    .meta_we      (meta_we),
    .meta_ctr     (meta_ctr),
    .tgt_we       (tgt_we),
    .wrong_path   (wrong_path),
    .resolved_npc (resolved_npc)
  );

  btb_lookup_sel #(.PC_W(PC_W), .TAG_W(TAG_W)) u_sel (
    .pc_q       (pc_q),
    .pc_tag_q   (pc_q[PC_W-1 -: TAG_W]),
    .row_valid  (rd_valid),
    .row_tag    (rd_tag),
    .row_ctr    (rd_ctr),
    .row_target (rd_target),
    .taken      (pred_taken),
    .npc        (pred_npc)
  );

  assign pred_valid = lk_vq;

  always_ff @(posedge clk) begin
    if (rst) begin
      mispredict  <= 1'b0;
      redirect_pc <= '0;
    end else begin
      mispredict  <= wrong_path;
      if (upd_valid) redirect_pc <= resolved_npc;
    end
  end

endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            fetch_valid,
  input logic [PC_W-1:0] fetch_pc,
  input logic            pred_valid,
  input logic            pred_taken,
  input logic [PC_W-1:0] pred_npc,
  input logic            upd_valid,
  input logic [PC_W-1:0] upd_pc,
  input logic            upd_taken,
  input logic [PC_W-1:0] upd_pred_npc,
  input logic            mispredict,
  input logic [PC_W-1:0] redirect_pc
);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!pred_valid && !mispredict));

  assert_pred_follows_fetch_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (pred_valid == $past(fetch_valid)));

  assert_not_taken_sequential_R3: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && !pred_taken) |-> (pred_npc == $past(fetch_pc) + PC_W'(4)));

  assert_flag_needs_update_R9: assert property (@(posedge clk) disable iff (rst)
    mispredict |-> $past(upd_valid));

  assert_flag_means_differs_R9: assert property (@(posedge clk) disable iff (rst)
    mispredict |-> (redirect_pc != $past(upd_pred_npc)));

  assert_fallthrough_redirect_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(upd_valid) && !$past(upd_taken)) |-> (redirect_pc == $past(upd_pc) + PC_W'(4)));

endmodule

bind btb_predictor btb_predictor_chk #(.PC_W(PC_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .fetch_valid  (fetch_valid),
  .fetch_pc     (fetch_pc),
  .pred_valid   (pred_valid),
  .pred_taken   (pred_taken),
  .pred_npc     (pred_npc),
  .upd_valid    (upd_valid),
  .upd_pc       (upd_pc),
  .upd_taken    (upd_taken),
  .upd_pred_npc (upd_pred_npc),
  .mispredict   (mispredict),
  .redirect_pc  (redirect_pc)
);

// File: tb/tb_btb_predictor.sv
module tb_btb_predictor;
  logic        clk = 1'b0;
  logic        rst;
  logic        fetch_valid;
  logic [31:0] fetch_pc;
  logic        pred_valid, pred_taken;
  logic [31:0] pred_npc;
  logic        upd_valid, upd_taken;
  logic [31:0] upd_pc, upd_target, upd_pred_npc;
  logic        mispredict;
  logic [31:0] redirect_pc;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  btb_predictor dut (
    .clk(clk), .rst(rst),
    .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_npc(pred_npc),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_target(upd_target),
    .upd_taken(upd_taken), .upd_pred_npc(upd_pred_npc),
    .mispredict(mispredict), .redirect_pc(redirect_pc)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Lookup: drive at a falling edge, sample at the next falling edge.
  task automatic lookup(input logic [31:0] pc, output logic [31:0] npc, output logic tk);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_pc = pc;
    @(negedge clk);
    fetch_valid = 1'b0;
    check(pred_valid == 1'b1, "R2 pred_valid", 32'(pred_valid), 32'd1);
    npc = pred_npc; tk = pred_taken;
  endtask

  task automatic update(input logic [31:0] pc, input logic [31:0] tgt, input logic tk,
                        input logic [31:0] pnpc, output logic mp, output logic [31:0] rd);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_target = tgt; upd_taken = tk; upd_pred_npc = pnpc;
    @(negedge clk);
    upd_valid = 1'b0;
    mp = mispredict; rd = redirect_pc;
  endtask

  task automatic expect_lookup(input logic [31:0] pc, input logic [31:0] exp_npc,
                               input logic exp_tk, input string req);
    logic [31:0] n; logic t;
    lookup(pc, n, t);
    check(n == exp_npc, req, n, exp_npc);
    check(t == exp_tk, req, 32'(t), 32'(exp_tk));
  endtask

  task automatic expect_update(input logic [31:0] pc, input logic [31:0] tgt, input logic tk,
                               input logic [31:0] pnpc, input logic exp_mp, input string req);
    logic m; logic [31:0] r; logic [31:0] resolved;
    resolved = tk ? tgt : pc + 32'd4;
    update(pc, tgt, tk, pnpc, m, r);
    check(m == exp_mp, {req, " mispredict"}, 32'(m), 32'(exp_mp));
    check(r == resolved, "R9 redirect_pc", r, resolved);
  endtask

  localparam logic [31:0] PA = 32'h0000_1008;
  localparam logic [31:0] TA = 32'h0000_2000;
  localparam logic [31:0] PB = 32'h0000_1048;

  task automatic t_reset();
    @(negedge clk);
    check(pred_valid == 1'b0, "R1 pred_valid after reset", 32'(pred_valid), 32'd0);
    check(mispredict == 1'b0, "R1 mispredict after reset", 32'(mispredict), 32'd0);
    expect_lookup(32'h0000_0100, 32'h0000_0104, 1'b0, "R1 empty table");
    @(negedge clk);
    check(pred_valid == 1'b0, "R2 no fetch no pred", 32'(pred_valid), 32'd0);
  endtask

  task automatic t_no_alloc();
    expect_update(PA, TA, 1'b0, PA + 4, 1'b0, "R9 correct fallthrough");
    expect_lookup(PA, PA + 4, 1'b0, "R5 not-taken miss leaves table");
  endtask

  task automatic t_alloc();
    expect_update(PA, TA, 1'b1, PA + 4, 1'b1, "R9 taken miss");
    expect_lookup(PA, TA, 1'b1, "R5 allocated weakly taken");
  endtask

  task automatic t_loop();
    expect_update(PA, TA, 1'b1, TA, 1'b0, "R9 correct taken");
    expect_update(PA, TA, 1'b0, TA, 1'b1, "R7 loop exit");
    expect_lookup(PA, TA, 1'b1, "R7 hysteresis keeps taken");
    expect_update(PA, TA, 1'b1, TA, 1'b0, "R7 loop reentry");
  endtask

  task automatic t_saturate();
    for (int k = 0; k < 3; k++) expect_update(PA, TA, 1'b1, TA, 1'b0, "R6 upper saturation");
    expect_update(PA, TA, 1'b0, TA, 1'b1, "R6 step down");
    expect_lookup(PA, TA, 1'b1, "R6 upper saturation held");
    expect_update(PA, TA, 1'b0, TA, 1'b1, "R6 to weakly not taken");
    expect_lookup(PA, PA + 4, 1'b0, "R3 counter msb 0");
    for (int k = 0; k < 3; k++) expect_update(PA, TA, 1'b0, PA + 4, 1'b0, "R6 lower saturation");
    expect_update(PA, TA, 1'b1, PA + 4, 1'b1, "R6 step up");
    expect_lookup(PA, PA + 4, 1'b0, "R6 lower saturation held");
    expect_update(PA, TA, 1'b1, PA + 4, 1'b1, "R6 to weakly taken");
    expect_lookup(PA, TA, 1'b1, "R6 weakly taken predicts");
  endtask

  task automatic t_alias();
    expect_lookup(PB, PB + 4, 1'b0, "R4 tag mismatch");
    expect_update(PB, 32'h0000_3000, 1'b1, PB + 4, 1'b1, "R4 alias alloc");
    expect_lookup(PA, PA + 4, 1'b0, "R4 evicted");
    expect_lookup(PB, 32'h0000_3000, 1'b1, "R4 new owner");
  endtask

  task automatic t_refresh();
    expect_update(PB, 32'h0000_3400, 1'b1, 32'h0000_3000, 1'b1, "R8 new target");
    expect_lookup(PB, 32'h0000_3400, 1'b1, "R8 target refreshed");
  endtask

  task automatic t_same_cycle();
    logic [31:0] pc_c = 32'h0000_4010;
    @(negedge clk);
    fetch_valid = 1'b1; fetch_pc = pc_c;
    upd_valid = 1'b1; upd_pc = pc_c; upd_target = 32'h0000_5000; upd_taken = 1'b1;
    upd_pred_npc = pc_c + 4;
    @(negedge clk);
    fetch_valid = 1'b0; upd_valid = 1'b0;
    check(pred_npc == pc_c + 4, "R10 old contents", pred_npc, pc_c + 4);
    check(mispredict == 1'b1, "R9 same-cycle mispredict", 32'(mispredict), 32'd1);
    expect_lookup(pc_c, 32'h0000_5000, 1'b1, "R10 write visible next");
  endtask

  task automatic t_all_rows();
    for (int i = 0; i < 16; i++) begin
      logic [31:0] pc = 32'h0000_8000 + 32'(i) * 4;
      expect_update(pc, 32'h0000_9000 + 32'(i) * 16, 1'b1, pc + 4, 1'b1, "R4 fill row");
    end
    for (int i = 0; i < 16; i++) begin
      logic [31:0] pc = 32'h0000_8000 + 32'(i) * 4;
      expect_lookup(pc, 32'h0000_9000 + 32'(i) * 16, 1'b1, "R4 row independent");
    end
  endtask

  initial begin
    rst = 1'b1; fetch_valid = 1'b0; fetch_pc = '0;
    upd_valid = 1'b0; upd_pc = '0; upd_target = '0; upd_taken = 1'b0; upd_pred_npc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_no_alloc();
    t_alloc();
    t_loop();
    t_saturate();
    t_alias();
    t_refresh();
    t_same_cycle();
    t_all_rows();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule